// File: doc/BRIEF.md
# Attention-Framed SPI Packet Reader

This block is the host end of a one-way SPI link to a peripheral that only transmits. The peripheral pulls an active-low attention line when it holds a packet. The reader then drives select low and waits out a setup delay. It then fetches the packet one byte at a time. Each byte takes eight serial clocks, and a quiet gap of fixed minimum length follows each byte. The serial clock idles high. The peripheral changes its data on the falling edge, so the reader samples on the rising edge, most significant bit first.

The byte count does not set where a packet ends. The attention line does. At the end of every inter-byte gap the reader looks at attention. If attention has gone high, the byte just fetched is the final one. It is delivered with a last flag, select is released and the clock stays parked high. If attention stays low for more bytes than a set limit, the reader gives up. It marks the byte it just read as last and aborted, releases select, and waits for attention to rise before it will start again.

The setup delay, the inter-byte gap and the serial clock half-period are parameters counted in system clock cycles. The defaults suit a 200 MHz system clock: 50 µs delays and a serial clock no faster than 500 kHz. Attention passes through a synchronizer before the control logic uses it.

Top module: `spi_packet_reader`

## Requirements
- R1: After reset, select (`ssN`) is high, `sclk` is high and `outValid` is low.
- R2: Select is driven low only after the synchronized attention input has been seen low; while attention stays high, select stays high and no clock runs.
- R3: The first falling `sclk` edge comes at least `SETUP_CYC` system clock cycles after select falls.
- R4: Within a byte, each `sclk` level lasts exactly `SCLK_HALF_CYC` cycles, and every byte has exactly `BYTE_W` rising edges.
- R5: Bits are sampled on rising `sclk` edges, most significant bit first. Each byte appears on `outData` with `outValid` high for exactly one cycle.
- R6: At least `GAP_CYC` cycles pass between the last rising edge of one byte and the first falling edge of the next.
- R7: If attention is high at the end of the gap after a byte, that byte carries `outLast` = 1, select goes high, and `sclk` stays high.
- R8: If attention is still low at the end of the gap after byte number `MAX_BYTES`, that byte carries both `outLast` = 1 and `outAbort` = 1, and select is released. Bytes not delivered this way carry `outAbort` = 0.
- R9: After an abort, select stays high and no further bytes are delivered until attention has returned high.
- R10: When attention has risen and the byte limit is reached at the same gap end, the packet ends normally (`outLast` = 1, `outAbort` = 0).
- R11: Whenever select is high, `sclk` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| atnN | input | 1 | Active-low attention from the peripheral (asynchronous) |
| miso | input | 1 | Serial data from the peripheral |
| ssN | output | 1 | Active-low select to the peripheral |
| sclk | output | 1 | Serial clock, idles high |
| outValid | output | 1 | One-cycle strobe: a received byte is on outData |
| outData | output | BYTE_W | Received byte |
| outLast | output | 1 | Byte is the final one of its packet |
| outAbort | output | 1 | Packet ended by the byte limit rather than by attention |

## Verification
At the gap end, two decisions fall in the same cycle: the attention check and the byte-limit check. They collide when a packet is exactly `MAX_BYTES` long. The bench provokes this with a peripheral model that raises attention right after the final rising edge of the fourth byte, using a limit of four. The run passes only if that byte comes out with the last flag set and the abort flag clear. A second run keeps attention low past the limit and must see the abort flag set. A third run checks that select stays released until attention rises.

// File: rtl/spr_pkg.sv
package spr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_SHIFT,
    ST_GAP,
    ST_DRAIN
  } rdState_t;

  // strobes from control to datapath, valid in the cycle they are high
  typedef struct packed {
    logic sampleBit;  // rising sclk edge this cycle: take miso
    logic emit;       // gap finished: publish assembled byte
    logic last;       // published byte closes the packet
    logic abort;      // packet closed by the byte limit
  } rdStrobe_t;

endpackage

// File: rtl/spr_ctrl.sv
module spr_ctrl
  import spr_pkg::*;
#(
  parameter int SCLK_HALF_CYC = 200,
  parameter int SETUP_CYC     = 10000,
  parameter int GAP_CYC       = 10000,
  parameter int MAX_BYTES     = 64,
  parameter int BYTE_W        = 8,
  parameter int SYNC_STAGES   = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      atnN,
  output logic      ssN,
  output logic      sclk,
  output rdStrobe_t strobe
);

  localparam int MAXA  = (SETUP_CYC > GAP_CYC) ? SETUP_CYC : GAP_CYC;
  localparam int MAXC  = (MAXA > SCLK_HALF_CYC) ? MAXA : SCLK_HALF_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam int BIT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam int BC_W  = $clog2(MAX_BYTES + 1);

  localparam logic [CNT_W-1:0] HALF_END  = CNT_W'(SCLK_HALF_CYC - 1);
  localparam logic [CNT_W-1:0] SETUP_END = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] GAP_END   = CNT_W'(GAP_CYC - 1);
  localparam logic [BIT_W-1:0] BIT_END   = BIT_W'(BYTE_W - 1);
  localparam logic [BC_W-1:0]  BYTE_LIM  = BC_W'(MAX_BYTES);

  rdState_t         state;
  logic [CNT_W-1:0] tick;
  logic [BIT_W-1:0] bitCnt;
  logic [BC_W-1:0]  byteCnt;
  logic [SYNC_STAGES-1:0] atnPipe;
  logic             atnLowS;
  logic             atLimit;

  // attention synchronizer, reset to "not requesting"
  always_ff @(posedge clk) begin
    if (!rstN) atnPipe <= '1;
    else       atnPipe <= {atnPipe[SYNC_STAGES-2:0], atnN};
  end
  assign atnLowS = !atnPipe[SYNC_STAGES-1];
  assign atLimit = (byteCnt == BYTE_LIM);

  always_comb begin
    strobe.sampleBit = (state == ST_SHIFT) && (tick == HALF_END) && !sclk;
    strobe.emit      = (state == ST_GAP) && (tick == GAP_END);
    strobe.last      = !atnLowS || atLimit;
    strobe.abort     = atnLowS && atLimit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tick    <= '0;
      bitCnt  <= '0;
      byteCnt <= '0;
      ssN     <= 1'b1;
      sclk    <= 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          ssN  <= 1'b1;
          sclk <= 1'b1;
          if (atnLowS) begin
            state   <= ST_SETUP;
            ssN     <= 1'b0;
            tick    <= '0;
            byteCnt <= '0;
          end
        end
        ST_SETUP: begin
          if (tick == SETUP_END) begin
            state  <= ST_SHIFT;
            tick   <= '0;
            bitCnt <= '0;
          end else tick <= tick + 1'b1;
        end
        ST_SHIFT: begin
          if (tick == HALF_END) begin
            tick <= '0;
            sclk <= !sclk;
            if (!sclk) begin
              if (bitCnt == BIT_END) begin
                state   <= ST_GAP;
                byteCnt <= byteCnt + 1'b1;
              end else bitCnt <= bitCnt + 1'b1;
            end
          end else tick <= tick + 1'b1;
        end
        ST_GAP: begin
          if (tick == GAP_END) begin
            tick <= '0;
            if (!atnLowS) begin
              state <= ST_IDLE;
              ssN   <= 1'b1;
            end else if (atLimit) begin
              state <= ST_DRAIN;
              ssN   <= 1'b1;
            end else begin
              state  <= ST_SHIFT;
              bitCnt <= '0;
            end
          end else tick <= tick + 1'b1;
        end
        ST_DRAIN: begin
          ssN  <= 1'b1;
          sclk <= 1'b1;
          if (!atnLowS) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_SCLK_PARKED: assert property (@(posedge clk) disable iff (!rstN)
    ssN |-> sclk); // R11
  AST_SELECT_NEEDS_ATN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ssN) |-> $past(atnLowS)); // R2
  AST_SAMPLE_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.sampleBit |=> ($rose(sclk) && !ssN)); // R5
  AST_BYTE_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    byteCnt <= BYTE_LIM); // R8
  AST_DRAIN_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DRAIN) |-> (ssN && !strobe.emit)); // R9

endmodule

// File: rtl/spr_datapath.sv
module spr_datapath
  import spr_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              miso,
  input  rdStrobe_t         strobe,
  output logic              outValid,
  output logic [BYTE_W-1:0] outData,
  output logic              outLast,
  output logic              outAbort
);

  logic [BYTE_W-1:0] shiftReg;

  // MSB arrives first, so new bits enter at the bottom
  always_ff @(posedge clk) begin
    if (!rstN) shiftReg <= '0;
    else if (strobe.sampleBit) shiftReg <= {shiftReg[BYTE_W-2:0], miso};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
      outLast  <= 1'b0;
      outAbort <= 1'b0;
    end else begin
      outValid <= strobe.emit;
      if (strobe.emit) begin
        outData  <= shiftReg;
        outLast  <= strobe.last;
        outAbort <= strobe.abort;
      end
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid); // R5
  AST_ABORT_MARKS_LAST: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outAbort) |-> outLast); // R8

endmodule

// File: rtl/spi_packet_reader.sv
module spi_packet_reader #(
  parameter int SCLK_HALF_CYC = 200,
  parameter int SETUP_CYC     = 10000,
  parameter int GAP_CYC       = 10000,
  parameter int MAX_BYTES     = 64,
  parameter int BYTE_W        = 8,
  parameter int SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              atnN,
  input  logic              miso,
  output logic              ssN,
  output logic              sclk,
  output logic              outValid,
  output logic [BYTE_W-1:0] outData,
  output logic              outLast,
  output logic              outAbort
);

  spr_pkg::rdStrobe_t strobe;

  spr_ctrl #(
    .SCLK_HALF_CYC(SCLK_HALF_CYC),
    .SETUP_CYC    (SETUP_CYC),
    .GAP_CYC      (GAP_CYC),
    .MAX_BYTES    (MAX_BYTES),
    .BYTE_W       (BYTE_W),
    .SYNC_STAGES  (SYNC_STAGES)
  ) uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .atnN  (atnN),
    .ssN   (ssN),
    .sclk  (sclk),
    .strobe(strobe)
  );

  spr_datapath #(
    .BYTE_W(BYTE_W)
  ) uData (
    .clk     (clk),
    .rstN    (rstN),
    .miso    (miso),
    .strobe  (strobe),
    .outValid(outValid),
    .outData (outData),
    .outLast (outLast),
    .outAbort(outAbort)
  );

endmodule

// File: tb/tb_spi_packet_reader.sv
module tb_spi_packet_reader;

  localparam int HALF  = 4;
  localparam int SETUP = 20;
  localparam int GAP   = 16;
  localparam int MAXB  = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic atnN = 1'b1;
  logic miso = 1'b0;
  logic ssN, sclk, outValid, outLast, outAbort;
  logic [7:0] outData;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = !clk;

  spi_packet_reader #(
    .SCLK_HALF_CYC(HALF), .SETUP_CYC(SETUP), .GAP_CYC(GAP),
    .MAX_BYTES(MAXB), .BYTE_W(8), .SYNC_STAGES(2)
  ) dut (
    .clk(clk), .rstN(rstN), .atnN(atnN), .miso(miso),
    .ssN(ssN), .sclk(sclk), .outValid(outValid), .outData(outData),
    .outLast(outLast), .outAbort(outAbort)
  );

  // ---------------- peripheral model ----------------
  logic [7:0] pkt [0:7];
  int pktLen = 0;
  bit holdLow = 0;
  int bitPos = 0;
  int byteIdx = 0;

  always @(negedge ssN) begin bitPos = 0; byteIdx = 0; end
  always @(negedge sclk) if (!ssN) miso = pkt[byteIdx % 8][7 - bitPos];
  always @(posedge sclk) if (!ssN) begin
    bitPos++;
    if (bitPos == 8) begin
      bitPos = 0;
      byteIdx++;
      if (byteIdx == pktLen && !holdLow) atnN = 1'b1;
    end
  end

  // ---------------- monitor (between edges) ----------------
  int cyc = 0;
  logic prevSs = 1'b1, prevSclk = 1'b1;
  int ssFallT = 0, lastRiseT = 0, lastFallT = 0, riseInPkt = 0;
  bit firstFall = 0;
  int setupMin = 1000000, gapMin = 1000000, halfMin = 1000000, halfMax = 0;
  int riseTotal = 0, parkErr = 0;
  logic [7:0] capData [0:15];
  bit capLast [0:15];
  bit capAbort [0:15];
  int capN = 0;

  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (ssN && !sclk) parkErr++;
      if (prevSs && !ssN) begin ssFallT = cyc; firstFall = 1; riseInPkt = 0; end
      if (prevSclk && !sclk) begin
        if (firstFall) begin
          if (cyc - ssFallT < setupMin) setupMin = cyc - ssFallT;
          firstFall = 0;
        end else if (riseInPkt % 8 == 0) begin
          if (cyc - lastRiseT < gapMin) gapMin = cyc - lastRiseT;
        end else begin
          if (cyc - lastRiseT < halfMin) halfMin = cyc - lastRiseT;
          if (cyc - lastRiseT > halfMax) halfMax = cyc - lastRiseT;
        end
        lastFallT = cyc;
      end
      if (!prevSclk && sclk) begin
        if (cyc - lastFallT < halfMin) halfMin = cyc - lastFallT;
        if (cyc - lastFallT > halfMax) halfMax = cyc - lastFallT;
        lastRiseT = cyc;
        riseInPkt++;
        riseTotal++;
      end
      if (outValid && capN < 16) begin
        capData[capN] = outData;
        capLast[capN] = outLast;
        capAbort[capN] = outAbort;
        capN++;
      end
    end
    prevSs = ssN;
    prevSclk = sclk;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tReset();
    repeat (4) @(negedge clk);
    check(ssN == 1'b1, "R1 ssN after reset", ssN, 1);
    check(sclk == 1'b1, "R1 sclk after reset", sclk, 1);
    check(outValid == 1'b0, "R1 outValid after reset", outValid, 0);
    rstN = 1'b1;
  endtask

  task automatic tIdleQuiet();
    int seen = 0;
    atnN = 1'b1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (!ssN || !sclk || outValid) seen++;
    end
    check(seen == 0, "R2 no select while attention high", seen, 0);
  endtask

  // len: bytes before attention rises; hold: never raise attention
  task automatic tPacket(input int len, input bit hold, input int expN, input int seed);
    int waitCyc = 0;
    for (int i = 0; i < 8; i++) pkt[i] = 8'((seed * 37 + i * 29) ^ 8'hA5);
    riseTotal = 0; capN = 0; pktLen = len; holdLow = hold;
    atnN = 1'b0;
    while (!(capN >= expN && ssN) && waitCyc < 4000) begin
      @(negedge clk); waitCyc++;
    end
    repeat (3) @(negedge clk);
    check(capN == expN, "R5 byte count delivered", capN, expN);
    for (int i = 0; i < expN && i < 16; i++) begin
      check(capData[i] == pkt[i], "R5 byte value MSB first", capData[i], pkt[i]);
      check(capLast[i] == (i == expN - 1), "R7 last flag position", capLast[i], (i == expN - 1));
      check(capAbort[i] == (hold && i == expN - 1), "R8/R10 abort flag", capAbort[i], (hold && i == expN - 1));
    end
    check(riseTotal == 8 * expN, "R4 rising edges per packet", riseTotal, 8 * expN);
    if (hold) begin
      int bad = 0;
      for (int i = 0; i < 50; i++) begin
        @(negedge clk);
        if (!ssN || !sclk) bad++;
      end
      check(bad == 0, "R9 select held off after abort", bad, 0);
      check(capN == expN, "R9 no bytes after abort", capN, expN);
      atnN = 1'b1;
      repeat (10) @(negedge clk);
    end else begin
      repeat (10) @(negedge clk);
    end
    check(ssN == 1'b1 && sclk == 1'b1, "R7 released and parked", {ssN, sclk}, 3);
  endtask

  initial begin
    tReset();
    tIdleQuiet();
    tPacket(3, 0, 3, 1);
    tPacket(1, 0, 1, 2);
    tPacket(MAXB, 0, MAXB, 3);   // R10 collision of limit and end
    tPacket(99, 1, MAXB, 4);     // R8 timeout
    tIdleQuiet();
    tPacket(2, 0, 2, 5);         // restart after abort
    check(setupMin >= SETUP, "R3 select-to-first-clock", setupMin, SETUP);
    check(gapMin >= GAP, "R6 inter-byte gap", gapMin, GAP);
    check(halfMin == HALF && halfMax == HALF, "R4 half period", halfMin, HALF);
    check(parkErr == 0, "R11 sclk high while deselected", parkErr, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule